// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block is the scheduling core of an instruction queue in an out-of-order pipeline. It keeps a fixed set of entry slots. Each slot holds a sequence number, an instruction class and a ready bit. Every cycle it picks ready entries to send to execution. Within one class the oldest entry goes first. Each class has its own per-cycle limit, and a shared issue width caps the total for the cycle. When classes compete for that width, they are served in a fixed order.

Entries come in through a one-per-cycle insert port. The port shows which slot the next entry will take, how many slots are free, and a full flag. Operand wakeup is done elsewhere and arrives as a per-slot mask that sets ready bits. A squash request carries a sequence number. It removes every entry younger than that number, youngest first, a few entries per cycle. While the squash runs, a stall output is raised, and both insertion and issue are held off.

Top module: `iq_issue_sel`

## Requirements
- R1: Age is judged by the wrap-aware difference of sequence numbers. Entry a is older than entry b when bit SEQ_W-1 of (a - b) mod 2^SEQ_W is set. Among ready entries of one class, older entries are always picked before younger ones.
- R2: Class codes are 0 integer, 1 floating-point, 2 branch, 3 memory and 4 misc. Codes 5 to 7 are stored and reported as 4. Issue lanes fill from lane 0 upward with no gaps. The classes appear in the code order above, and each class group runs oldest first.
- R3: The number of issued entries of a class in one cycle never exceeds that class's limit (INT_LIM, FP_LIM, BR_LIM, MEM_LIM, MISC_LIM).
- R4: The total issued in one cycle never exceeds ISSUE_W. When the width runs out, classes with lower codes keep their picks.
- R5: After reset the queue is empty: free_cnt equals ENTRIES, full is low, stall is low and no lane is valid. An accepted insert takes the lowest-numbered free slot, shown on ins_slot. free_cnt counts the empty slots, and full is high exactly when free_cnt is 0. An insert while full is ignored.
- R6: Issue is computed from the registered state. An entry inserted ready, or woken in a given cycle, can issue no earlier than the next cycle. An issued entry's slot is freed at the same clock edge.
- R7: wake_mask bit i sets the ready bit of slot i if that slot is occupied. A wake bit for an empty slot has no effect on a later insert into that slot.
- R8: A squash request on sq_valid, taken when no squash is running, raises stall from the next cycle. Each stalled cycle removes up to SQ_PER_CYC of the youngest entries that are strictly younger than sq_seq. Stall drops after the cycle in which the last such entry is removed, and lasts at least one cycle.
- R9: In a cycle with sq_valid high or stall high, no insert is accepted and no lane is valid. A squash request that arrives during stall is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert request |
| ins_seq | input | SEQ_W | Sequence number of the inserted entry |
| ins_cls | input | 3 | Class code of the inserted entry |
| ins_rdy | input | 1 | Inserted entry is ready at insertion |
| ins_slot | output | $clog2(ENTRIES) | Slot the next accepted insert will occupy |
| free_cnt | output | $clog2(ENTRIES+1) | Number of empty slots |
| full | output | 1 | No empty slot |
| wake_mask | input | ENTRIES | Per-slot ready set |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Squash boundary; younger entries are removed |
| stall | output | 1 | Squash in progress |
| iss_valid | output | ISSUE_W | Per-lane issue valid |
| iss_seq | output | ISSUE_W x SEQ_W | Per-lane issued sequence number |
| iss_cls | output | ISSUE_W x 3 | Per-lane issued class |

## Verification
A wrong ready bit, a wrong class or a wrong age rank shows up on the issue lanes in the first cycle that the entry is eligible. The entry appears in the wrong lane, too early, or not at all, and a slot that is not freed shows one cycle later on free_cnt and ins_slot. A squash that removes the wrong entries or too many per cycle shows as a stall of the wrong length. It also shows as a free count that differs from the reference once the stall ends. The bench compares every output against a cycle model on every cycle, under random traffic that crosses sequence wraparound many times. It also runs directed cases for full queue, out-of-order sequence numbers, width contention and multi-cycle squash.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int NUM_CLS = 5;

  typedef enum logic [2:0] {
    CLS_INT  = 3'd0,
    CLS_FP   = 3'd1,
    CLS_BR   = 3'd2,
    CLS_MEM  = 3'd3,
    CLS_MISC = 3'd4
  } iq_cls_e;

  // wrap-aware age test: a older than b when (a-b) is negative in w bits
  function automatic logic seq_older(input logic [31:0] a, input logic [31:0] b, input int w);
    logic [31:0] d;
    d = a - b;
    return d[w-1];
  endfunction

  // out-of-range class codes fold into misc
  function automatic logic [2:0] cls_norm(input logic [2:0] c);
    return (c > 3'(CLS_MISC)) ? 3'(CLS_MISC) : c;
  endfunction
endpackage

// File: rtl/iq_class_pick.sv
module iq_class_pick
  import iq_pkg::*;
#(
  parameter int N     = 8,
  parameter int SEQ_W = 6,
  parameter int LIMIT = 2,
  parameter int CNT_W = 4
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     cand,
  input  logic [SEQ_W-1:0] seq   [N],
  output logic [N-1:0]     sel,
  output logic [CNT_W-1:0] rank  [N],
  output logic [CNT_W-1:0] taken
);
  int older_cnt [N];
  int tot;

  always_comb begin
    tot = 0;
    for (int i = 0; i < N; i++) begin
      older_cnt[i] = 0;
      for (int j = 0; j < N; j++) begin
        if (j != i && cand[j] && seq_older(32'(seq[j]), 32'(seq[i]), SEQ_W))
          older_cnt[i] = older_cnt[i] + 1;
      end
      rank[i] = CNT_W'(older_cnt[i]);
      sel[i]  = cand[i] && (older_cnt[i] < LIMIT);
      if (sel[i]) tot = tot + 1;
    end
    taken = CNT_W'(tot);
  end

  // R3
  class_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel) <= LIMIT);
endmodule

// File: rtl/iq_squash_pick.sv
module iq_squash_pick
  import iq_pkg::*;
#(
  parameter int N       = 8,
  parameter int SEQ_W   = 6,
  parameter int PER_CYC = 2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [SEQ_W-1:0] tgt,
  input  logic [N-1:0]     valid,
  input  logic [SEQ_W-1:0] seq  [N],
  output logic [N-1:0]     kill,
  output logic             last
);
  logic [N-1:0] victim;
  int younger_cnt [N];
  int nvic;

  always_comb begin
    nvic = 0;
    for (int i = 0; i < N; i++) begin
      victim[i] = valid[i] && seq_older(32'(tgt), 32'(seq[i]), SEQ_W);
      if (victim[i]) nvic = nvic + 1;
    end
    for (int i = 0; i < N; i++) begin
      younger_cnt[i] = 0;
      for (int j = 0; j < N; j++) begin
        if (j != i && victim[j] && seq_older(32'(seq[i]), 32'(seq[j]), SEQ_W))
          younger_cnt[i] = younger_cnt[i] + 1;
      end
      kill[i] = active && victim[i] && (younger_cnt[i] < PER_CYC);
    end
    last = (nvic <= PER_CYC);
  end

  // R8
  kill_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(kill) <= PER_CYC);
  // R8
  kill_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kill & ~valid) == '0);
endmodule

// File: rtl/iq_issue_merge.sv
module iq_issue_merge
  import iq_pkg::*;
#(
  parameter int N       = 8,
  parameter int SEQ_W   = 6,
  parameter int ISSUE_W = 3,
  parameter int CNT_W   = 4
)(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N-1:0]                   sel,
  input  logic [CNT_W-1:0]               rank  [N],
  input  logic [2:0]                     cls   [N],
  input  logic [SEQ_W-1:0]               seq   [N],
  input  logic [CNT_W-1:0]               taken [NUM_CLS],
  output logic [N-1:0]                   grant,
  output logic [ISSUE_W-1:0]             lane_valid,
  output logic [ISSUE_W-1:0][SEQ_W-1:0]  lane_seq,
  output logic [ISSUE_W-1:0][2:0]        lane_cls
);
  logic [CNT_W-1:0] off [NUM_CLS];
  logic [CNT_W-1:0] pos [N];

  always_comb begin
    off[0] = '0;
    for (int c = 1; c < NUM_CLS; c++) off[c] = off[c-1] + taken[c-1];
    for (int i = 0; i < N; i++) begin
      pos[i]   = off[cls_norm(cls[i])] + rank[i];
      grant[i] = sel[i] && (int'(pos[i]) < ISSUE_W);
    end
    lane_valid = '0;
    lane_seq   = '0;
    lane_cls   = '0;
    for (int k = 0; k < ISSUE_W; k++) begin
      for (int i = 0; i < N; i++) begin
        if (grant[i] && int'(pos[i]) == k) begin
          lane_valid[k] = 1'b1;
          lane_seq[k]   = seq[i];
          lane_cls[k]   = cls[i];
        end
      end
    end
  end

  // R4
  total_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) <= ISSUE_W);
  // R4
  lane_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) == $countones(lane_valid));
endmodule

// File: rtl/iq_issue_sel.sv
module iq_issue_sel
  import iq_pkg::*;
#(
  parameter int ENTRIES    = 8,
  parameter int SEQ_W      = 6,
  parameter int INT_LIM    = 2,
  parameter int FP_LIM     = 1,
  parameter int BR_LIM     = 1,
  parameter int MEM_LIM    = 1,
  parameter int MISC_LIM   = 1,
  parameter int ISSUE_W    = 3,
  parameter int SQ_PER_CYC = 2
)(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               ins_valid,
  input  logic [SEQ_W-1:0]                   ins_seq,
  input  logic [2:0]                         ins_cls,
  input  logic                               ins_rdy,
  output logic [$clog2(ENTRIES)-1:0]         ins_slot,
  output logic [$clog2(ENTRIES+1)-1:0]       free_cnt,
  output logic                               full,
  input  logic [ENTRIES-1:0]                 wake_mask,
  input  logic                               sq_valid,
  input  logic [SEQ_W-1:0]                   sq_seq,
  output logic                               stall,
  output logic [ISSUE_W-1:0]                 iss_valid,
  output logic [ISSUE_W-1:0][SEQ_W-1:0]      iss_seq,
  output logic [ISSUE_W-1:0][2:0]            iss_cls
);
  localparam int N     = ENTRIES;
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int CNT_W = $clog2(ENTRIES + 1);

  function automatic int lim_of(input int c);
    case (c)
      0:       return INT_LIM;
      1:       return FP_LIM;
      2:       return BR_LIM;
      3:       return MEM_LIM;
      default: return MISC_LIM;
    endcase
  endfunction

  // entry state
  logic [N-1:0]     ent_v;
  logic [N-1:0]     ent_rdy;
  logic [SEQ_W-1:0] ent_seq [N];
  logic [2:0]       ent_cls [N];
  logic             sq_busy;
  logic [SEQ_W-1:0] sq_tgt;

  // named internal events
  logic             ins_acc;
  logic             issue_en;
  logic [N-1:0]     grant;
  logic [N-1:0]     kill;
  logic             sq_last;
  logic             sq_start;

  always_comb begin
    free_cnt = CNT_W'(N - $countones(ent_v));
    full     = (ent_v == '1);
    ins_slot = '0;
    for (int i = N - 1; i >= 0; i--) if (!ent_v[i]) ins_slot = IDX_W'(i);
  end

  assign stall    = sq_busy;
  assign issue_en = !sq_busy && !sq_valid;
  assign ins_acc  = ins_valid && !full && !sq_busy && !sq_valid;
  assign sq_start = sq_valid && !sq_busy;

  // per-class age pools
  logic [N-1:0]     cand_c  [NUM_CLS];
  logic [N-1:0]     sel_c   [NUM_CLS];
  logic [CNT_W-1:0] rank_c  [NUM_CLS][N];
  logic [CNT_W-1:0] taken_c [NUM_CLS];

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_pool
    always_comb begin
      for (int i = 0; i < N; i++)
        cand_c[g][i] = issue_en && ent_v[i] && ent_rdy[i] && (ent_cls[i] == 3'(g));
    end
    iq_class_pick #(.N(N), .SEQ_W(SEQ_W), .LIMIT(lim_of(g)), .CNT_W(CNT_W)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .cand  (cand_c[g]),
      .seq   (ent_seq),
      .sel   (sel_c[g]),
      .rank  (rank_c[g]),
      .taken (taken_c[g])
    );
  end

  logic [N-1:0]     ent_sel;
  logic [CNT_W-1:0] ent_rank [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      ent_sel[i]  = 1'b0;
      ent_rank[i] = '0;
      for (int c = 0; c < NUM_CLS; c++) begin
        if (ent_cls[i] == 3'(c)) begin
          ent_sel[i]  = sel_c[c][i];
          ent_rank[i] = rank_c[c][i];
        end
      end
    end
  end

  iq_issue_merge #(.N(N), .SEQ_W(SEQ_W), .ISSUE_W(ISSUE_W), .CNT_W(CNT_W)) u_merge (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (ent_sel),
    .rank       (ent_rank),
    .cls        (ent_cls),
    .seq        (ent_seq),
    .taken      (taken_c),
    .grant      (grant),
    .lane_valid (iss_valid),
    .lane_seq   (iss_seq),
    .lane_cls   (iss_cls)
  );

  iq_squash_pick #(.N(N), .SEQ_W(SEQ_W), .PER_CYC(SQ_PER_CYC)) u_squash (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (sq_busy),
    .tgt    (sq_tgt),
    .valid  (ent_v),
    .seq    (ent_seq),
    .kill   (kill),
    .last   (sq_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v   <= '0;
      ent_rdy <= '0;
      sq_busy <= 1'b0;
      sq_tgt  <= '0;
      for (int i = 0; i < N; i++) begin
        ent_seq[i] <= '0;
        ent_cls[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (kill[i] || grant[i]) begin
          ent_v[i]   <= 1'b0;
          ent_rdy[i] <= 1'b0;
        end else if (ins_acc && ins_slot == IDX_W'(i)) begin
          ent_v[i]   <= 1'b1;
          ent_rdy[i] <= ins_rdy;
          ent_seq[i] <= ins_seq;
          ent_cls[i] <= cls_norm(ins_cls);
        end else if (ent_v[i] && wake_mask[i]) begin
          ent_rdy[i] <= 1'b1;
        end
      end
      if (sq_start) begin
        sq_busy <= 1'b1;
        sq_tgt  <= sq_seq;
      end else if (sq_busy && sq_last) begin
        sq_busy <= 1'b0;
      end
    end
  end

  for (genvar k = 0; k + 1 < ISSUE_W; k++) begin : g_lane_chk
    // R2
    lane_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[k+1] |-> iss_valid[k]);
    // R2
    lane_cls_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[k+1] |-> (iss_cls[k] <= iss_cls[k+1]));
    // R1
    lane_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid[k+1] && iss_cls[k] == iss_cls[k+1])
        |-> seq_older(32'(iss_seq[k]), 32'(iss_seq[k+1]), SEQ_W));
  end

  // R8
  squash_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sq_start |=> stall);
  // R9
  stall_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> free_cnt >= $past(free_cnt));
  // R9
  stall_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> iss_valid == '0);
endmodule

// File: tb/iq_issue_sel_test.sv
module iq_issue_sel_test;
  localparam int CLK_P = 10;
  localparam int N = 8;
  localparam int SW = 6;
  localparam int IW = 3;
  localparam int LIM [5] = '{2, 1, 1, 1, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid = 1'b0;
  logic [SW-1:0] ins_seq = '0;
  logic [2:0] ins_cls = '0;
  logic ins_rdy = 1'b0;
  logic [2:0] ins_slot;
  logic [3:0] free_cnt;
  logic full;
  logic [N-1:0] wake_mask = '0;
  logic sq_valid = 1'b0;
  logic [SW-1:0] sq_seq = '0;
  logic stall;
  logic [IW-1:0] iss_valid;
  logic [IW-1:0][SW-1:0] iss_seq;
  logic [IW-1:0][2:0] iss_cls;

  always #(CLK_P/2) clk = ~clk;

  iq_issue_sel uut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_seq(ins_seq),
    .ins_cls(ins_cls), .ins_rdy(ins_rdy), .ins_slot(ins_slot),
    .free_cnt(free_cnt), .full(full), .wake_mask(wake_mask),
    .sq_valid(sq_valid), .sq_seq(sq_seq), .stall(stall),
    .iss_valid(iss_valid), .iss_seq(iss_seq), .iss_cls(iss_cls)
  );

  int n_chk = 0;
  int n_bad = 0;
  int next_seq = 0;

  // reference model state
  bit mv [N];
  bit mr [N];
  int ms [N];
  int mc [N];
  bit msq;
  int mtgt;
  bit used [N];
  int e_free, e_slot, e_lv [IW], e_ls [IW], e_lc [IW];

  function automatic bit b_older(int a, int b);
    return ((a - b) & ((1 << SW) - 1)) >= (1 << (SW - 1));
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin mv[i] = 0; mr[i] = 0; ms[i] = 0; mc[i] = 0; end
    msq = 0; mtgt = 0;
  endtask

  task automatic model_outputs(input bit sv);
    int nl, best;
    e_free = 0; e_slot = -1;
    for (int i = 0; i < N; i++) begin
      used[i] = 0;
      if (!mv[i]) begin e_free++; if (e_slot < 0) e_slot = i; end
    end
    if (e_slot < 0) e_slot = 0;
    for (int k = 0; k < IW; k++) begin e_lv[k] = 0; e_ls[k] = 0; e_lc[k] = 0; end
    nl = 0;
    if (!msq && !sv) begin
      for (int c = 0; c < 5; c++) begin
        for (int t = 0; t < LIM[c]; t++) begin
          best = -1;
          for (int i = 0; i < N; i++)
            if (mv[i] && mr[i] && mc[i] == c && !used[i] && (best < 0 || b_older(ms[i], ms[best])))
              best = i;
          if (best >= 0 && nl < IW) begin
            used[best] = 1; e_lv[nl] = 1; e_ls[nl] = ms[best]; e_lc[nl] = c; nl++;
          end
        end
      end
    end
  endtask

  task automatic model_step(input bit iv, input int ic, input bit ir, input int is,
                            input logic [N-1:0] wm, input bit sv, input int ss);
    bit killed [N];
    int nv, yb;
    bit acc, last;
    for (int i = 0; i < N; i++) killed[i] = 0;
    last = 0;
    if (msq) begin
      nv = 0;
      for (int i = 0; i < N; i++) if (mv[i] && b_older(mtgt, ms[i])) nv++;
      last = (nv <= 2);
      for (int r = 0; r < 2; r++) begin
        yb = -1;
        for (int i = 0; i < N; i++)
          if (mv[i] && !killed[i] && b_older(mtgt, ms[i]) && (yb < 0 || b_older(ms[yb], ms[i])))
            yb = i;
        if (yb >= 0) killed[yb] = 1;
      end
    end
    acc = iv && (e_free > 0) && !msq && !sv;
    for (int i = 0; i < N; i++) begin
      if (killed[i] || used[i]) begin mv[i] = 0; mr[i] = 0; end
      else if (mv[i] && wm[i]) mr[i] = 1;
    end
    if (acc) begin
      mv[e_slot] = 1; mr[e_slot] = ir; ms[e_slot] = is; mc[e_slot] = (ic > 4) ? 4 : ic;
    end
    if (!msq && sv) begin msq = 1; mtgt = ss; end
    else if (msq && last) msq = 0;
  endtask

  task automatic step(input bit iv, input int ic, input bit ir, input int is,
                      input logic [N-1:0] wm, input bit sv, input int ss, input string tag);
    @(negedge clk);
    ins_valid = iv; ins_cls = 3'(ic); ins_rdy = ir; ins_seq = SW'(is);
    wake_mask = wm; sq_valid = sv; sq_seq = SW'(ss);
    #1;
    model_outputs(sv);
    check(tag, "free_cnt", int'(free_cnt), e_free);
    check(tag, "full", int'(full), int'(e_free == 0));
    check(tag, "stall", int'(stall), int'(msq));
    if (e_free > 0) check(tag, "ins_slot", int'(ins_slot), e_slot);
    for (int k = 0; k < IW; k++) begin
      check(tag, "lane valid", int'(iss_valid[k]), e_lv[k]);
      if (e_lv[k]) begin
        check(tag, "lane seq", int'(iss_seq[k]), e_ls[k]);
        check(tag, "lane cls", int'(iss_cls[k]), e_lc[k]);
      end
    end
    @(posedge clk);
    model_step(iv, ic, ir, is, wm, sv, ss);
  endtask

  task automatic idle(input int n, input logic [N-1:0] wm, input string tag);
    for (int c = 0; c < n; c++) step(0, 0, 0, 0, wm, 0, 0, tag);
  endtask

  task automatic put(input int ic, input bit ir, input int is, input string tag);
    step(1, ic, ir, is, '0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int s0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R5 reset state
    idle(1, '0, "R5 reset");

    // R5 fill to full, insert while full ignored
    for (int i = 0; i < N; i++) put(0, 0, 20 + i, "R5 fill");
    put(0, 1, 40, "R5 insert while full");
    idle(1, '0, "R5 full hold");
    // R3 int limit, R1 oldest first
    idle(6, '1, "R3 R1 int drain");

    // R1 wraparound and out-of-order seq numbers
    put(0, 0, 1, "R1 wrap");
    put(0, 0, 63, "R1 wrap");
    put(0, 0, 0, "R1 wrap");
    put(0, 0, 62, "R1 wrap");
    idle(4, '1, "R1 wrap issue");

    // R6 ready-at-insert issues one cycle later
    put(3, 1, 5, "R6 same cycle");
    idle(2, '0, "R6 next cycle");

    // R4 R2 width contention and class order, R3 fp limit
    put(4, 0, 10, "R2 mix");
    put(3, 0, 11, "R2 mix");
    put(2, 0, 12, "R2 mix");
    put(1, 0, 13, "R3 mix");
    put(1, 0, 14, "R3 mix");
    put(0, 0, 15, "R4 mix");
    put(6, 0, 16, "R2 code fold");
    idle(1, '1, "R4 wake all");
    idle(5, '0, "R4 R2 R3 contention");

    // R7 wake on empty slot ignored
    idle(1, '1, "R7 wake empty");
    put(0, 0, 30, "R7 insert after wake");
    idle(2, '0, "R7 no issue");
    idle(2, '1, "R7 drain");

    // R8 R9 multi-cycle squash
    for (int i = 0; i < N; i++) put(i % 5, 0, 40 + i, "R8 fill");
    step(1, 0, 1, 50, '1, 1, 42, "R9 sq cycle");
    step(1, 0, 1, 50, '1, 1, 44, "R9 stall insert");
    step(1, 1, 1, 50, '0, 0, 0, "R8 stall");
    idle(3, '0, "R8 stall end");
    idle(4, '1, "R8 survivors");
    // R8 squash with no victims still stalls one cycle
    step(0, 0, 0, 0, '0, 1, 9, "R8 empty squash");
    idle(2, '0, "R8 empty squash");

    // random traffic, crosses seq wraparound many times
    void'($urandom(32'd7));
    next_seq = 0;
    for (int c = 0; c < 3000; c++) begin
      bit iv, sv;
      int ic, ss;
      logic [N-1:0] wm;
      iv = ($urandom % 10) < 6;
      ic = (($urandom % 20) == 0) ? 5 + ($urandom % 3) : ($urandom % 5);
      wm = N'($urandom);
      sv = ($urandom % 40) == 0;
      ss = (next_seq - 1 - int'($urandom % 10)) & 63;
      s0 = e_free;
      model_outputs(sv);
      step(iv, ic, ($urandom % 4) == 0, next_seq, wm, sv, ss, "R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
      if (iv && e_free > 0 && !stall && !sv) next_seq = (next_seq + 1) & 63;
    end

    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule